// File: doc/BRIEF.md
# I/Q Converter Self-Calibration Controller

This block is the register-side controller for calibrating a pair of converter channels, called I (channel 0) and Q (channel 1). Software reaches it through a byte-wide register port. It keeps the per-channel calibration options, derives a gated calibration tick from the main clock by a programmable power-of-two ratio, and owns a 64-entry by 6-bit coefficient store. Software reads and writes that store indirectly through an address register and a data register.

Calibration is modelled behaviourally. A start command latches the channels that take part and their reference values. The run then completes after a fixed number of calibration ticks. On completion, each participating channel writes its reference into entry 0 of its half of the store, raises a sticky done flag, and marks its store as self-calibrated. A direct write to the store marks the affected half as user-calibrated. An uncalibrate command restores that half to defaults.

Top module: `iq_cal_ctrl`

## Requirements
- R1: With the tick enabled and divide code k (0 to 7) in CFG[2:0], `cal_tick` pulses for one cycle every 2^(8-k) clock cycles. The first pulse comes 2^(8-k) cycles after the enabling write.
- R2: While the clock-enable bit CFG[3] is 0, `cal_tick` stays low and the divider count restarts from zero.
- R3: The register map is as follows.
  - Address 0 is CFG: bit7 Q preload, bit6 I preload, bit5 Q select, bit4 I select, bit3 clock enable, bits 2:0 divide code. All eight bits read back as written.
  - Address 1 is STAT, read-only: bit7 Q done, bit6 I done, bit4 busy, bits 3:2 Q store status, bits 1:0 I store status.
  - Address 2 is MADDR (6 bits). Address 3 is MDATA (6 bits). Address 4 is CMD. Address 7 is ID.
  - Read data appears on `reg_rdata` in the cycle after `reg_re` and holds until the next read.
  - After reset every register reads 0, except ID.
- R4: Writing CMD bit4 with at least one select bit set starts a run: STAT busy goes to 1. The run finishes after 4 calibration ticks, so it never finishes while the clock enable is 0.
- R5: A finished run sets the done bit of each participating channel. That bit stays set until software writes 1 to its clear bit in CMD (bit7 clears Q, bit6 clears I). A clear for one channel leaves the other channel's bit alone.
- R6: Store status is encoded 00 uncalibrated, 01 self-calibrated, 10 user-calibrated, and is never 11. A finished run sets 01 for each participating channel only.
- R7: A start written while a run is in progress has no effect on which channels the run covers. A start written with no select bit set does not start a run.
- R8: At reset every coefficient entry is 32. Writing CMD bit0 (I) or bit1 (Q) resets all 32 entries of that channel's half to 32 and sets its status to 00; the other half is untouched. Within a half, uncalibrate takes priority over a run's result, and a run's result takes priority over a user write.
- R9: Coefficient access works through MADDR and MDATA.
  - CMD bit3 stores MDATA at entry MADDR. CMD bit2 loads MDATA from entry MADDR, and the value is readable from the next cycle.
  - Entries 0 to 31 belong to I and entries 32 to 63 belong to Q. A store write sets that channel's status to 10.
  - CMD always reads as 0, and MADDR and MDATA keep only their low 6 bits.
- R10: On completion, the reference is written into entry 0 of the channel's half (entry 0 for I, entry 32 for Q). The reference is taken when the run starts: it is 32 when the channel's preload bit is 0, and otherwise the value of entry 1 of that half (entry 1 for I, entry 33 for Q).
- R11: ID reads the constant 0x5A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_re | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | 8 | Registered read data |
| cal_tick | output | 1 | Divided calibration tick, one cycle wide |

## Verification
The divider is swept over all eight codes. Both the delay to the first tick and the spacing between ticks are measured, so an off-by-one in the count is caught as well as a wrong code mapping. The store is written at every entry with an address-dependent pattern and read back in full, which exposes address aliasing and half-boundary mistakes before an uncalibrate of one half shows that the other half survives. Calibration runs are made with preload off and preload on, and with a second start and a changed select pattern issued mid-run, so the done flags, status codes and written result show which channels a run really covered and where its reference came from.

// File: rtl/iq_cal_pkg.sv
package iq_cal_pkg;

   localparam int NCH  = 2;
   localparam int CH_I = 0;
   localparam int CH_Q = 1;

   typedef enum logic [1:0] {
      MS_UNCAL = 2'b00,
      MS_SELF  = 2'b01,
      MS_USER  = 2'b10
   } memst_e;

   // register addresses
   localparam logic [2:0] RA_CFG   = 3'd0;
   localparam logic [2:0] RA_STAT  = 3'd1;
   localparam logic [2:0] RA_MADDR = 3'd2;
   localparam logic [2:0] RA_MDATA = 3'd3;
   localparam logic [2:0] RA_CMD   = 3'd4;
   localparam logic [2:0] RA_ID    = 3'd7;

   // field positions (channel c sits at LSB + c)
   localparam int CFG_PRE_LSB   = 6;
   localparam int CFG_SEL_LSB   = 4;
   localparam int CFG_CLKEN     = 3;
   localparam int CMD_CLR_LSB   = 6;
   localparam int CMD_START     = 4;
   localparam int CMD_MWR       = 3;
   localparam int CMD_MRD       = 2;
   localparam int CMD_UNCAL_LSB = 0;

endpackage

// File: rtl/iq_cal_div.sv
module iq_cal_div #(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   localparam int CNT_W = 1 << CODE_W;

   if (CODE_W < 1 || CODE_W > 4) begin : g_bad_code_w
      $error("iq_cal_div: CODE_W must lie in 1..4");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] mask;

   // code k keeps the low (CNT_W-k) bits: ratio 2^(CNT_W-k)
   assign mask = {CNT_W{1'b1}} >> code;
   assign tick = en && ((cnt & mask) == mask);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) cnt <= '0;
      else               cnt <= cnt + 1'b1;
   end

   // mask bit 0 is always set, so a tick needs an odd count and is never followed by one
   assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/iq_cal_coefmem.sv
module iq_cal_coefmem #(
   parameter int AW  = 6,
   parameter int DW  = 6,
   parameter int NCH = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    uwr,
   input  logic [AW-1:0]           uaddr,
   input  logic [DW-1:0]           udata,
   input  logic [AW-1:0]           raddr,
   output logic [DW-1:0]           rdata,
   input  logic [NCH-1:0]          cwe,
   input  logic [NCH-1:0][DW-1:0]  cdata,
   input  logic [NCH-1:0]          clr,
   output logic [NCH-1:0][DW-1:0]  pre_word
);
   localparam int DEPTH = 1 << AW;
   localparam int HALF  = DEPTH / NCH;
   localparam logic [DW-1:0] DEF = DW'(1 << (DW - 1));

   if (NCH != 2 || HALF < 2) begin : g_bad_geom
      $error("iq_cal_coefmem: two channels with at least two entries each required");
   end

   logic [DW-1:0] word [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      localparam int CH  = e / HALF;
      localparam int OFF = e % HALF;
      logic [DW-1:0] q;
      logic          cal_hit;
      if (OFF == 0) begin : g_res
         assign cal_hit = cwe[CH];
      end else begin : g_plain
         assign cal_hit = 1'b0;
      end
      always_ff @(posedge clk) begin
         if (!rst_n)                              q <= DEF;
         else if (clr[CH])                        q <= DEF;
         else if (cal_hit)                        q <= cdata[CH];
         else if (uwr && uaddr == AW'(e))         q <= udata;
      end
      assign word[e] = q;
   end

   assign rdata = word[raddr];

   for (genvar c = 0; c < NCH; c++) begin : g_pre
      assign pre_word[c] = word[c*HALF + 1];

      assert_uncal_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
         clr[c] |=> pre_word[c] == DEF);
   end

endmodule

// File: rtl/iq_cal_engine.sv
module iq_cal_engine
   import iq_cal_pkg::*;
#(
   parameter int NCH   = 2,
   parameter int DW    = 6,
   parameter int TICKS = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic                    start,
   input  logic [NCH-1:0]          sel,
   input  logic [NCH-1:0]          pre,
   input  logic [NCH-1:0][DW-1:0]  user_ref,
   input  logic [NCH-1:0]          clr_done,
   input  logic [NCH-1:0]          uncal,
   input  logic [NCH-1:0]          user_wr,
   output logic                    busy,
   output logic [NCH-1:0]          done,
   output logic [NCH-1:0][1:0]     memst,
   output logic [NCH-1:0]          cwe,
   output logic [NCH-1:0][DW-1:0]  cdata
);
   localparam int TW = $clog2(TICKS + 1);
   localparam logic [DW-1:0] DEF = DW'(1 << (DW - 1));

   if (TICKS < 1) begin : g_bad_ticks
      $error("iq_cal_engine: TICKS must be at least 1");
   end

   logic [NCH-1:0] act;
   logic [TW-1:0]  tcnt;
   logic           accept;
   logic           finish;

   assign accept = start && !busy && (|sel);
   assign finish = busy && tick && (tcnt == TW'(TICKS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         act  <= '0;
         tcnt <= '0;
      end else if (accept) begin
         busy <= 1'b1;
         act  <= sel;
         tcnt <= '0;
      end else if (busy && tick) begin
         if (finish) busy <= 1'b0;
         else        tcnt <= tcnt + 1'b1;
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [DW-1:0] ref_q;
      logic          done_q;
      logic [1:0]    ms_q;

      always_ff @(posedge clk) begin
         if (!rst_n)      ref_q <= DEF;
         else if (accept) ref_q <= pre[c] ? user_ref[c] : DEF;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)                  done_q <= 1'b0;
         else if (finish && act[c])   done_q <= 1'b1;
         else if (clr_done[c])        done_q <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)                  ms_q <= MS_UNCAL;
         else if (uncal[c])           ms_q <= MS_UNCAL;
         else if (finish && act[c])   ms_q <= MS_SELF;
         else if (user_wr[c])         ms_q <= MS_USER;
      end

      assign done[c]  = done_q;
      assign memst[c] = ms_q;
      assign cwe[c]   = finish && act[c];
      assign cdata[c] = ref_q;

      assert_done_from_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(done[c]) |-> $past(busy));

      assert_memst_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
         memst[c] != 2'b11);
   end

   assert_run_set_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(act));

endmodule

// File: rtl/iq_cal_ctrl.sv
module iq_cal_ctrl
   import iq_cal_pkg::*;
#(
   parameter int         ADDR_W     = 3,
   parameter int         DIV_CODE_W = 3,
   parameter int         COEF_W     = 6,
   parameter int         MEM_AW     = 6,
   parameter int         CAL_TICKS  = 4,
   parameter logic [7:0] ID_VAL     = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   input  logic              reg_we,
   input  logic              reg_re,
   output logic [7:0]        reg_rdata,
   output logic              cal_tick
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("iq_cal_ctrl: ADDR_W must be at least 3");
   end
   if (DIV_CODE_W < 1 || DIV_CODE_W > 3) begin : g_bad_div
      $error("iq_cal_ctrl: DIV_CODE_W must lie in 1..3");
   end
   if (COEF_W < 2 || COEF_W > 8 || MEM_AW < 2 || MEM_AW > 8) begin : g_bad_mem
      $error("iq_cal_ctrl: COEF_W and MEM_AW must lie in 2..8");
   end

   // ---------------- configuration and indirect registers
   logic [NCH-1:0]        cfg_pre, cfg_sel;
   logic                  cfg_clken;
   logic [DIV_CODE_W-1:0] cfg_div;
   logic [MEM_AW-1:0]     maddr;
   logic [COEF_W-1:0]     mdata;

   logic wr_cfg, wr_maddr, wr_mdata, wr_cmd;
   assign wr_cfg   = reg_we && (reg_addr == ADDR_W'(RA_CFG));
   assign wr_maddr = reg_we && (reg_addr == ADDR_W'(RA_MADDR));
   assign wr_mdata = reg_we && (reg_addr == ADDR_W'(RA_MDATA));
   assign wr_cmd   = reg_we && (reg_addr == ADDR_W'(RA_CMD));

   // command bits act in the cycle they are written and are not stored
   logic                 c_start, c_mwr, c_mrd;
   logic [NCH-1:0]       c_clr, c_uncal, user_wr_ch;
   assign c_start = wr_cmd && reg_wdata[CMD_START];
   assign c_mwr   = wr_cmd && reg_wdata[CMD_MWR];
   assign c_mrd   = wr_cmd && reg_wdata[CMD_MRD];

   for (genvar c = 0; c < NCH; c++) begin : g_cmd
      assign c_clr[c]      = wr_cmd && reg_wdata[CMD_CLR_LSB + c];
      assign c_uncal[c]    = wr_cmd && reg_wdata[CMD_UNCAL_LSB + c];
      assign user_wr_ch[c] = c_mwr && (maddr[MEM_AW-1] == 1'(c));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_pre   <= '0;
         cfg_sel   <= '0;
         cfg_clken <= 1'b0;
         cfg_div   <= '0;
      end else if (wr_cfg) begin
         cfg_pre   <= reg_wdata[CFG_PRE_LSB +: NCH];
         cfg_sel   <= reg_wdata[CFG_SEL_LSB +: NCH];
         cfg_clken <= reg_wdata[CFG_CLKEN];
         cfg_div   <= reg_wdata[DIV_CODE_W-1:0];
      end
   end

   logic [COEF_W-1:0] mem_rd;

   always_ff @(posedge clk) begin
      if (!rst_n)        maddr <= '0;
      else if (wr_maddr) maddr <= reg_wdata[MEM_AW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        mdata <= '0;
      else if (c_mrd)    mdata <= mem_rd;
      else if (wr_mdata) mdata <= reg_wdata[COEF_W-1:0];
   end

   // ---------------- divider
   iq_cal_div #(.CODE_W(DIV_CODE_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (cfg_clken),
      .code (cfg_div),
      .tick (cal_tick)
   );

   // ---------------- coefficient store and engine
   logic                        busy;
   logic [NCH-1:0]              done, cwe;
   logic [NCH-1:0][1:0]         memst;
   logic [NCH-1:0][COEF_W-1:0]  cdata, pre_word;

   iq_cal_coefmem #(.AW(MEM_AW), .DW(COEF_W), .NCH(NCH)) u_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .uwr     (c_mwr),
      .uaddr   (maddr),
      .udata   (mdata),
      .raddr   (maddr),
      .rdata   (mem_rd),
      .cwe     (cwe),
      .cdata   (cdata),
      .clr     (c_uncal),
      .pre_word(pre_word)
   );

   iq_cal_engine #(.NCH(NCH), .DW(COEF_W), .TICKS(CAL_TICKS)) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (cal_tick),
      .start   (c_start),
      .sel     (cfg_sel),
      .pre     (cfg_pre),
      .user_ref(pre_word),
      .clr_done(c_clr),
      .uncal   (c_uncal),
      .user_wr (user_wr_ch),
      .busy    (busy),
      .done    (done),
      .memst   (memst),
      .cwe     (cwe),
      .cdata   (cdata)
   );

   // ---------------- read path
   logic [7:0] cfg_view, stat_view, rd_mux;
   assign cfg_view  = {cfg_pre[CH_Q], cfg_pre[CH_I], cfg_sel[CH_Q], cfg_sel[CH_I],
                       cfg_clken, 3'(cfg_div)};
   assign stat_view = {done[CH_Q], done[CH_I], 1'b0, busy, memst[CH_Q], memst[CH_I]};

   always_comb begin
      rd_mux = 8'h00;
      if      (reg_addr == ADDR_W'(RA_CFG))   rd_mux = cfg_view;
      else if (reg_addr == ADDR_W'(RA_STAT))  rd_mux = stat_view;
      else if (reg_addr == ADDR_W'(RA_MADDR)) rd_mux = 8'(maddr);
      else if (reg_addr == ADDR_W'(RA_MDATA)) rd_mux = 8'(mdata);
      else if (reg_addr == ADDR_W'(RA_ID))    rd_mux = ID_VAL;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      reg_rdata <= 8'h00;
      else if (reg_re) reg_rdata <= rd_mux;
   end

   assert_tick_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cal_tick |-> cfg_clken);

   assert_cmd_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_re && reg_addr == ADDR_W'(RA_CMD)) |=> reg_rdata == 8'h00);

   assert_mem_read_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
      c_mrd |=> mdata == $past(mem_rd));

endmodule

// File: tb/iq_cal_ctrl_tb.sv
module iq_cal_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       reg_we = 1'b0;
   logic       reg_re = 1'b0;
   logic [7:0] reg_rdata;
   logic       cal_tick;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   always #2 clk = ~clk;   // 250 MHz

   iq_cal_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .cal_tick(cal_tick)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_re = 1'b1;
      @(negedge clk);
      reg_re = 1'b0;
      d = reg_rdata;
   endtask

   task automatic mem_wr(input int a, input int v);
      wr(3'd2, 8'(a));
      wr(3'd3, 8'(v));
      wr(3'd4, 8'h08);
   endtask

   task automatic mem_rd(input int a, output logic [7:0] d);
      wr(3'd2, 8'(a));
      wr(3'd4, 8'h04);
      rd(3'd3, d);
   endtask

   task automatic wait_idle(input string tag);
      logic [7:0] s;
      for (int n = 0; n < 2000; n++) begin
         rd(3'd1, s);
         if (!s[4]) return;
      end
      chk(tag, 1, 0);
   endtask

   function automatic int pat(input int a);
      return (a * 5 + 7) % 64;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(3'd0, d); chk("R3 CFG reset", d, 8'h00);
      rd(3'd1, d); chk("R3 STAT reset", d, 8'h00);
      rd(3'd2, d); chk("R3 MADDR reset", d, 8'h00);
      rd(3'd3, d); chk("R3 MDATA reset", d, 8'h00);
      rd(3'd7, d); chk("R11 ID", d, 8'h5A);
      mem_rd(5, d); chk("R8 entry reset value", d, 32);

      // register readback
      wr(3'd0, 8'hA5); rd(3'd0, d); chk("R3 CFG readback", d, 8'hA5);
      wr(3'd2, 8'hFF); rd(3'd2, d); chk("R9 MADDR width", d, 8'h3F);
      wr(3'd3, 8'hFF); rd(3'd3, d); chk("R9 MDATA width", d, 8'h3F);
      wr(3'd4, 8'h00); rd(3'd4, d); chk("R9 CMD reads 0", d, 8'h00);

      // R1 divider sweep: first-tick delay and spacing for every code
      for (int k = 0; k < 8; k++) begin
         int n, i, j;
         n = 1 << (8 - k);
         wr(3'd0, 8'h00);
         wr(3'd0, 8'h08 | 8'(k));
         i = 1;
         while (!cal_tick && i < 600) begin @(negedge clk); i++; end
         chk($sformatf("R1 first tick code %0d", k), i, n);
         j = 0;
         do begin @(negedge clk); j++; end while (!cal_tick && j < 600);
         chk($sformatf("R1 tick period code %0d", k), j, n);
      end

      // R2: disabled clock gives no tick
      begin
         int seen = 0;
         wr(3'd0, 8'h07);
         for (int t = 0; t < 300; t++) begin @(negedge clk); if (cal_tick) seen++; end
         chk("R2 no tick while disabled", seen, 0);
      end

      // R9: full store round-trip
      for (int a = 0; a < 64; a++) mem_wr(a, pat(a));
      begin
         int errs = 0;
         for (int a = 0; a < 64; a++) begin
            mem_rd(a, d);
            if (d != 8'(pat(a))) begin
               errs++;
               $display("FAIL R9 entry %0d: actual=0x%0h expected=0x%0h", a, d, pat(a));
            end
         end
         total++; if (errs != 0) bad++;
      end
      rd(3'd1, d); chk("R9 user status both halves", d, 8'h0A);

      // R8: uncalibrate I half only
      wr(3'd4, 8'h01);
      rd(3'd1, d); chk("R8 I status cleared", d, 8'h08);
      mem_rd(1, d);  chk("R8 I entry default", d, 32);
      mem_rd(31, d); chk("R8 I last entry default", d, 32);
      mem_rd(33, d); chk("R8 Q half untouched", d, pat(33));

      // R4/R7: run on I with clock stopped, second start with both selected ignored
      mem_wr(0, 5);
      wr(3'd0, 8'h17);
      wr(3'd4, 8'h10);
      repeat (50) @(negedge clk);
      rd(3'd1, d); chk("R4 busy, no completion while clock off", d, 8'h1A);
      wr(3'd0, 8'h30);
      wr(3'd4, 8'h10);
      wr(3'd0, 8'h3F);
      wait_idle("R4 run completes");
      rd(3'd1, d); chk("R7 R6 only I finished, I self-cal", d, 8'h49);
      mem_rd(0, d); chk("R10 I result without preload", d, 32);

      // R5: sticky done and per-channel clears
      repeat (20) @(negedge clk);
      wr(3'd4, 8'h80);
      rd(3'd1, d); chk("R5 Q clear leaves I done", d, 8'h49);
      wr(3'd4, 8'h40);
      rd(3'd1, d); chk("R5 I clear", d, 8'h09);

      // R10: Q run with preload from entry 33
      mem_wr(33, 19);
      wr(3'd0, 8'hAF);
      wr(3'd4, 8'h10);
      wait_idle("R4 Q run completes");
      rd(3'd1, d); chk("R6 Q self-cal, done Q", d, 8'h85);
      mem_rd(32, d); chk("R10 Q result from preload", d, 19);

      // R7: start with nothing selected
      wr(3'd0, 8'h0F);
      wr(3'd4, 8'h10);
      rd(3'd1, d); chk("R7 empty select no run", d, 8'h85);

      // R8: uncalibrate Q
      wr(3'd4, 8'h02);
      rd(3'd1, d); chk("R8 Q status cleared", d, 8'h81);
      mem_rd(32, d); chk("R8 Q entry 32 default", d, 32);
      mem_rd(0, d);  chk("R8 I half untouched", d, 32);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule